// File: doc/BRIEF.md
# Tail-Pointer Descriptor Ring Controller

This block drives one channel's circular ring of fixed-size descriptors. Software gives it a ring base address, a ring length counted in descriptors, and a tail pointer. The tail pointer is the address just past the last descriptor that software has made ready. The controller keeps a current-descriptor pointer. While that pointer differs from the tail, the controller fetches the descriptor at the current pointer over a memory read port. It hands the descriptor downstream with a valid/ready handshake and then steps the pointer forward. After the last slot of the ring, the pointer wraps back to the base. When the current pointer reaches the tail, the controller parks in a suspended state. It leaves that state once software moves the tail to a different address. The block has no logic tied to transmit or receive, so one copy serves either direction.

Each descriptor is 16 bytes, so slot `i` sits at `base + 16*i`. Only one fetch is outstanding at any time. A start bit in the control register enables the engine, and setting it rewinds the pointer to the base.

The controller is a six-state machine:
- `ST_IDLE`: the start bit is clear. Goes to `ST_CHECK` once the start bit is set.
- `ST_CHECK`: compares the current pointer with the tail. Goes to `ST_IDLE` if the start bit is clear, to `ST_SUSP` if the two are equal, and to `ST_FETCH` otherwise.
- `ST_FETCH`: the read request is raised. Goes to `ST_WAIT` when the request is accepted.
- `ST_WAIT`: waits for the read data. Goes to `ST_HAND` when the data arrives and captures it.
- `ST_HAND`: offers the descriptor downstream. Goes to `ST_CHECK` on acceptance and advances the pointer.
- `ST_SUSP`: parked. Goes to `ST_IDLE` if the start bit is cleared, and to `ST_CHECK` as soon as the tail differs from the current pointer.

Top module: `desc_ring_ctrl`

## Requirements
- R1: Configuration writes use `cfg_addr` 0 for control (bit 0 is start), 1 for ring base, 2 for ring length in descriptors, and 3 for tail address. A write that sets start while start is clear puts `cur_ptr` at the base address.
- R2: Each fetch request carries the address `base + 16*index`, and each descriptor is requested once. While `rd_req_ready` is low, the request stays raised with a stable address.
- R3: When `cur_ptr` equals the tail, `suspended` goes high and no further fetch requests are issued.
- R4: A tail write that makes the tail differ from `cur_ptr` clears `suspended`, and fetching resumes at `cur_ptr`.
- R5: After the descriptor at `base + 16*(length-1)` is accepted, `cur_ptr` returns to the base address, and the next fetch goes to the base.
- R6: At most one fetch is outstanding. No new request is issued until the previous descriptor has been accepted downstream, and `dsc_valid` stays high with stable `dsc_data` until `dsc_ready`.
- R7: While the start bit is clear, the engine issues no fetch requests, even if the tail differs from `cur_ptr`.
- R8: The read data is passed to `dsc_data` unchanged, and `cur_ptr` advances by 16 each time a descriptor is accepted.
- R9: A tail write while a fetch is in flight does not cancel that fetch. The new tail is used at the next comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | AW | Configuration write data |
| rd_req_valid | output | 1 | Descriptor fetch request |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | AW | Fetch byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | DW | Descriptor read data |
| dsc_valid | output | 1 | Descriptor offered downstream |
| dsc_ready | input | 1 | Downstream accepts the descriptor |
| dsc_data | output | DW | Descriptor contents |
| cur_ptr | output | AW | Current descriptor address |
| suspended | output | 1 | Engine parked with current equal to tail |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 128-bit descriptors and an 8-bit length field. It programs a four-slot ring, which is short enough for a single resume to cross the wrap and land exactly on the tail. It holds the memory request port and the consumer ready low for several cycles, to show that requests and descriptors are held and that a second fetch never starts early. Tail writes are timed while a fetch is in flight and while the engine is stopped. This shows that the new tail is used only at the next comparison, and that it is ignored while the start bit is clear.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FETCH,
        ST_WAIT,
        ST_HAND,
        ST_SUSP
    } ring_state_e;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_BASE = 2'd1;
    localparam logic [1:0] REG_LEN  = 2'd2;
    localparam logic [1:0] REG_TAIL = 2'd3;

endpackage

// File: rtl/desc_ring_regs.sv
module desc_ring_regs
    import desc_ring_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [AW-1:0] cfg_wdata,
    output logic          start_q,
    output logic          start_rise,
    output logic [AW-1:0] base_q,
    output logic [LW-1:0] len_q,
    output logic [AW-1:0] tail_q
);

    logic unused_wdata_bits;
    assign unused_wdata_bits = ^cfg_wdata[AW-1:LW];

    // pulse that rewinds the pointer when the engine is switched on
    assign start_rise = cfg_we && (cfg_addr == REG_CTRL) && cfg_wdata[0] && !start_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            base_q  <= '0;
            len_q   <= '0;
            tail_q  <= '0;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                REG_CTRL: start_q <= cfg_wdata[0];
                REG_BASE: base_q  <= cfg_wdata;
                REG_LEN:  len_q   <= cfg_wdata[LW-1:0];
                REG_TAIL: tail_q  <= cfg_wdata;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/desc_ring_ptr.sv
module desc_ring_ptr #(
    parameter int AW    = 32,
    parameter int LW    = 8,
    parameter int SHIFT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    input  logic [AW-1:0] base,
    input  logic [LW-1:0] len,
    output logic [AW-1:0] cur_ptr
);

    logic [LW-1:0] idx_q;
    logic [LW:0]   idx_nxt;
    logic          at_end;

    assign idx_nxt = {1'b0, idx_q} + 1'b1;
    assign at_end  = idx_nxt >= {1'b0, len};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clr) begin
            idx_q <= '0;
        end else if (adv) begin
            idx_q <= at_end ? '0 : idx_nxt[LW-1:0];
        end
    end

    assign cur_ptr = base + (AW'(idx_q) << SHIFT);

endmodule

// File: rtl/desc_ring_fsm.sv
module desc_ring_fsm
    import desc_ring_pkg::*;
#(
    parameter int DW = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_q,
    input  logic          ptr_eq,
    input  logic          rd_req_ready,
    input  logic          rd_rsp_valid,
    input  logic [DW-1:0] rd_rsp_data,
    input  logic          dsc_ready,
    output logic          rd_req_valid,
    output logic          dsc_valid,
    output logic [DW-1:0] dsc_data,
    output logic          adv,
    output logic          suspended
);

    ring_state_e state_q, state_d;
    logic [DW-1:0] data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_q) state_d = ST_CHECK;
            ST_CHECK: begin
                if (!start_q)    state_d = ST_IDLE;
                else if (ptr_eq) state_d = ST_SUSP;
                else             state_d = ST_FETCH;
            end
            ST_FETCH: if (rd_req_ready) state_d = ST_WAIT;
            ST_WAIT:  if (rd_rsp_valid) state_d = ST_HAND;
            ST_HAND:  if (dsc_ready)    state_d = ST_CHECK;
            ST_SUSP: begin
                if (!start_q)     state_d = ST_IDLE;
                else if (!ptr_eq) state_d = ST_CHECK;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_WAIT && rd_rsp_valid) data_q <= rd_rsp_data;
        end
    end

    always_comb begin
        rd_req_valid = 1'b0;
        dsc_valid    = 1'b0;
        suspended    = 1'b0;
        unique case (state_q)
            ST_FETCH: rd_req_valid = 1'b1;
            ST_HAND:  dsc_valid    = 1'b1;
            ST_SUSP:  suspended    = 1'b1;
            default:  ;
        endcase
    end

    assign adv      = dsc_valid && dsc_ready;
    assign dsc_data = data_q;

endmodule

// File: rtl/desc_ring_ctrl.sv
module desc_ring_ctrl #(
    parameter int AW         = 32,
    parameter int DW         = 128,
    parameter int LW         = 8,
    parameter int DESC_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [AW-1:0] cfg_wdata,
    output logic          rd_req_valid,
    input  logic          rd_req_ready,
    output logic [AW-1:0] rd_req_addr,
    input  logic          rd_rsp_valid,
    input  logic [DW-1:0] rd_rsp_data,
    output logic          dsc_valid,
    input  logic          dsc_ready,
    output logic [DW-1:0] dsc_data,
    output logic [AW-1:0] cur_ptr,
    output logic          suspended
);

    localparam int SHIFT = $clog2(DESC_BYTES);

    logic          start_q;
    logic          start_rise;
    logic [AW-1:0] base_q;
    logic [LW-1:0] len_q;
    logic [AW-1:0] tail_q;
    logic          adv;
    logic          ptr_eq;

    desc_ring_regs #(.AW(AW), .LW(LW)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .start_q    (start_q),
        .start_rise (start_rise),
        .base_q     (base_q),
        .len_q      (len_q),
        .tail_q     (tail_q)
    );

    desc_ring_ptr #(.AW(AW), .LW(LW), .SHIFT(SHIFT)) ptr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start_rise),
        .adv     (adv),
        .base    (base_q),
        .len     (len_q),
        .cur_ptr (cur_ptr)
    );

    assign ptr_eq      = (cur_ptr == tail_q);
    assign rd_req_addr = cur_ptr;

    desc_ring_fsm #(.DW(DW)) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_q      (start_q),
        .ptr_eq       (ptr_eq),
        .rd_req_ready (rd_req_ready),
        .rd_rsp_valid (rd_rsp_valid),
        .rd_rsp_data  (rd_rsp_data),
        .dsc_ready    (dsc_ready),
        .rd_req_valid (rd_req_valid),
        .dsc_valid    (dsc_valid),
        .dsc_data     (dsc_data),
        .adv          (adv),
        .suspended    (suspended)
    );

endmodule

// File: rtl/desc_ring_ctrl_chk.sv
module desc_ring_ctrl_chk #(
    parameter int AW    = 32,
    parameter int DW    = 128,
    parameter int LW    = 8,
    parameter int SHIFT = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic          rd_req_valid,
    input logic          rd_req_ready,
    input logic [AW-1:0] rd_req_addr,
    input logic          dsc_valid,
    input logic          dsc_ready,
    input logic [DW-1:0] dsc_data,
    input logic [AW-1:0] cur_ptr,
    input logic          suspended,
    input logic          start_q,
    input logic [AW-1:0] base_q,
    input logic [LW-1:0] len_q,
    input logic [AW-1:0] tail_q
);

    logic [AW-1:0] last_addr;
    assign last_addr = base_q + (AW'(len_q - 1'b1) << SHIFT);

    a_r1_start_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_q) |-> cur_ptr == base_q);

    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

    a_r3_suspend_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> !rd_req_valid && !dsc_valid);

    a_r4_resume: assert property (@(posedge clk) disable iff (!rst_n)
        suspended && start_q && cur_ptr != tail_q |=> !suspended);

    a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_valid && dsc_ready && !cfg_we && cur_ptr == last_addr |=> cur_ptr == base_q);

    a_r6_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> !dsc_valid);

    a_r6_dsc_held: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_valid && !dsc_ready |=> dsc_valid && $stable(dsc_data));

    a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_valid && dsc_ready && !cfg_we && cur_ptr != last_addr
        |=> cur_ptr == $past(cur_ptr) + (AW'(1) << SHIFT));

endmodule

bind desc_ring_ctrl desc_ring_ctrl_chk #(.AW(AW), .DW(DW), .LW(LW), .SHIFT(SHIFT)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .dsc_valid    (dsc_valid),
    .dsc_ready    (dsc_ready),
    .dsc_data     (dsc_data),
    .cur_ptr      (cur_ptr),
    .suspended    (suspended),
    .start_q      (start_q),
    .base_q       (base_q),
    .len_q        (len_q),
    .tail_q       (tail_q)
);

// File: tb/desc_ring_ctrl_tb_top.sv
`timescale 1ns/1ps
module desc_ring_ctrl_tb_top;

    localparam int AW = 32;
    localparam int DW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          rd_req_valid;
    logic          rd_req_ready = 1'b1;
    logic [AW-1:0] rd_req_addr;
    logic          rd_rsp_valid = 1'b0;
    logic [DW-1:0] rd_rsp_data = '0;
    logic          dsc_valid;
    logic          dsc_ready = 1'b1;
    logic [DW-1:0] dsc_data;
    logic [AW-1:0] cur_ptr;
    logic          suspended;

    int checks = 0;
    int fails = 0;
    int fetch_cnt = 0;
    logic [AW-1:0] fetch_log [0:63];

    always #2.5 clk = ~clk;

    desc_ring_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rd_req_valid(rd_req_valid),
        .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .dsc_valid(dsc_valid), .dsc_ready(dsc_ready), .dsc_data(dsc_data),
        .cur_ptr(cur_ptr), .suspended(suspended)
    );

    function automatic logic [DW-1:0] pattern(input logic [AW-1:0] a);
        return {a ^ 32'h5A5A_0000, ~a, a, a + 32'd1};
    endfunction

    // behavioural memory: one-cycle read latency, logs every accepted fetch
    always @(posedge clk) begin
        rd_rsp_valid <= 1'b0;
        if (rd_req_valid && rd_req_ready) begin
            rd_rsp_valid <= 1'b1;
            rd_rsp_data  <= pattern(rd_req_addr);
            if (fetch_cnt < 64) fetch_log[fetch_cnt] <= rd_req_addr;
            fetch_cnt <= fetch_cnt + 1;
        end
    end

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R8: data passed through unchanged, checked on every handoff
    always @(negedge clk) begin
        if (rst_n && dsc_valid && dsc_ready) begin
            checks++;
            if (dsc_data !== pattern(cur_ptr)) begin
                fails++;
                $display("FAIL R8: actual %0h expected %0h", dsc_data, pattern(cur_ptr));
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_susp();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (suspended) return;
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic t_reset();
        check("reset suspended", suspended, 0);
        check("reset req", rd_req_valid, 0);
        check("reset dsc", dsc_valid, 0);
        check("reset ptr", cur_ptr, 0);
    endtask

    task automatic t_idle();   // R7
        wr(2'd1, 32'h1000);
        wr(2'd2, 32'd4);
        wr(2'd3, 32'h1020);
        repeat (20) @(negedge clk);
        check("R7 no fetch while stopped", fetch_cnt, 0);
        check("R7 not suspended", suspended, 0);
    endtask

    task automatic t_start();  // R1 R2 R3
        rd_req_ready = 1'b0;
        wr(2'd0, 32'd1);
        check("R1 pointer at base", cur_ptr, 32'h1000);
        repeat (6) @(negedge clk);
        check("R2 request held", rd_req_valid, 1);
        check("R2 held address", rd_req_addr, 32'h1000);
        check("R2 nothing accepted", fetch_cnt, 0);
        rd_req_ready = 1'b1;
        wait_susp();
        check("R3 suspended", suspended, 1);
        check("R3 fetch count", fetch_cnt, 2);
        check("R2 fetch 0", fetch_log[0], 32'h1000);
        check("R2 fetch 1", fetch_log[1], 32'h1010);
        check("R3 ptr at tail", cur_ptr, 32'h1020);
        repeat (10) @(negedge clk);
        check("R3 no fetch while suspended", fetch_cnt, 2);
    endtask

    task automatic t_wrap();   // R4 R5
        wr(2'd3, 32'h1000);
        @(negedge clk);
        check("R4 resumed", suspended, 0);
        wait_susp();
        check("R5 fetch count", fetch_cnt, 4);
        check("R4 fetch 2", fetch_log[2], 32'h1020);
        check("R5 fetch 3 last slot", fetch_log[3], 32'h1030);
        check("R5 wrapped to base", cur_ptr, 32'h1000);
        check("R5 suspended on wrap", suspended, 1);
    endtask

    task automatic t_backpressure();  // R6
        dsc_ready = 1'b0;
        wr(2'd3, 32'h1020);
        repeat (12) @(negedge clk);
        check("R6 single fetch outstanding", fetch_cnt, 5);
        check("R6 descriptor held", dsc_valid, 1);
        check("R6 ptr not advanced", cur_ptr, 32'h1000);
        dsc_ready = 1'b1;
        wait_susp();
        check("R6 fetch 4", fetch_log[4], 32'h1000);
        check("R6 fetch 5", fetch_log[5], 32'h1010);
        check("R6 ptr at tail", cur_ptr, 32'h1020);
    endtask

    task automatic t_inflight();  // R9
        dsc_ready = 1'b0;
        wr(2'd3, 32'h1000);
        for (int i = 0; i < 50 && !dsc_valid; i++) @(negedge clk);
        wr(2'd3, 32'h1030);
        dsc_ready = 1'b1;
        wait_susp();
        check("R9 in-flight fetch done", fetch_cnt, 7);
        check("R9 fetch address", fetch_log[6], 32'h1020);
        check("R9 new tail used", cur_ptr, 32'h1030);
    endtask

    task automatic t_stop_restart();  // R7 R1
        wr(2'd0, 32'd0);
        @(negedge clk);
        check("R7 left suspend when stopped", suspended, 0);
        wr(2'd3, 32'h1010);
        repeat (20) @(negedge clk);
        check("R7 tail write ignored while stopped", fetch_cnt, 7);
        wr(2'd3, 32'h1000);
        wr(2'd0, 32'd1);
        check("R1 restart rewinds", cur_ptr, 32'h1000);
        wait_susp();
        check("R1 base equals tail suspends", suspended, 1);
        check("R1 no fetch", fetch_cnt, 7);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_idle();
        t_start();
        t_wrap();
        t_backpressure();
        t_inflight();
        t_stop_restart();
        repeat (5) @(negedge clk);
        summary();
    end

endmodule